// File: doc/BRIEF.md
# Serial Timecode Frame Transmitter

This block sends time information down a single serial line, one bit per clock, at a 25 ns bit period. When the line has no frame to carry, it sends a continuous stream of K28.5 comma symbols. A send request names the current time: a 40-bit seconds count, a 28-bit nanoseconds count, four status flags and a 32-bit spill number. The block accepts the request only at a symbol boundary and only when no frame is pending. It then builds a 20-byte frame, most significant byte first, and appends a CRC-32 over the first 16 bytes. Each byte is line-coded with 8b10b and running disparity, and the symbols are shifted out.

The first bit of the frame goes onto the line in the clock after acceptance. That edge is the instant the timestamp stands for, so the time source should present a value that is valid for the next bit period. A `busy_o` flag covers exactly the 200 bit periods of the frame. A request held high sends frames back to back.

Top module: `tcode_serializer`

## Requirements
- R1: After reset, `busy_o` is low and the line carries K28.5 idle symbols (data 0xBC, control). The first symbol uses negative starting disparity and disparity alternates from then on, so the idle stream repeats 0011111010 then 1100000101.
- R2: Each symbol occupies 10 consecutive clocks, one bit per clock, sent in the order a,b,c,d,e,i,f,g,h,j. After reset the line shows bit a of the first idle symbol.
- R3: `send_i` is sampled only in the clock that shows bit j (the last bit) of a symbol, and only when no frame byte remains to be sent. A request at any other time has no effect on the line or on `busy_o`.
- R4: On acceptance, the next clock shows bit a of frame byte 0. `busy_o` is high for exactly 200 clocks, from that clock to the last bit of byte 19.
- R5: Byte 0 is the frame type 0x01. Bytes 1 to 5 carry seconds bits 39..0, most significant byte first.
- R6: Byte 6 carries the flags in bits 7..4 and nanoseconds bits 27..24 in bits 3..0. Bytes 7 to 9 carry nanoseconds bits 23..0, most significant byte first. The flag bits from 3 to 0 are time_valid, ptp_wr_mode, ptp_mode, ntp_mode.
- R7: Bytes 10 to 13 carry the spill number, most significant byte first. Bytes 14 and 15 are zero.
- R8: Bytes 16 to 19 hold a CRC-32 over bytes 0 to 15, most significant byte first. The CRC uses the reflected polynomial 0xEDB88320, processes each byte LSB first, starts at all ones and inverts its result.
- R9: Data bytes use standard 8b10b codes. Running disparity carries across idle and data symbols, including the alternate D.x.A7 codes and the complemented D.x.3 and D.7.y codes.
- R10: If a request is present on the last bit of byte 19, the next frame starts in the following clock and `busy_o` does not drop.
- R11: Frame contents are captured in the accepting clock. Input changes during a frame do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Request to send a timecode frame |
| sec_i | input | 40 | Seconds count |
| nsec_i | input | 28 | Nanoseconds count |
| flags_i | input | 4 | Status flags {time_valid, ptp_wr_mode, ptp_mode, ntp_mode} |
| sid_i | input | 32 | Spill number |
| line_o | output | 1 | Serial line output |
| busy_o | output | 1 | High while a frame symbol is on the line |

## Verification
The bench drives requests that arrive in the middle of a symbol and requests that arrive during a frame. A design that did not gate the request to the boundary would start a frame misaligned or corrupt the frame in flight. It also changes every input field partway through a frame, which catches a design that reads the fields live instead of capturing them at acceptance. Frames with all-ones, all-zero and mixed fields exercise the A7 and complemented codes and the carrying of disparity across symbols. A wrong table entry or a disparity slip shows up as a wrong bit on the line, tagged with the byte group it falls in. A held request checks the 400-clock back-to-back case, where a design with a gap cycle between frames would drop `busy_o` or insert an idle symbol.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int SYM_W     = 10;
    localparam int FRAME_LEN = 20;
    localparam int CRC_FIRST = 16;
    localparam int SEC_W     = 40;
    localparam int NS_W      = 28;
    localparam int FLAG_W    = 4;
    localparam int SID_W     = 32;
    localparam int CRC_W     = 32;
    localparam int HDR_BITS  = 8 * CRC_FIRST;
    localparam int RSV_W     = HDR_BITS - 8 - SEC_W - FLAG_W - NS_W - SID_W;
    localparam int CNT_W     = $clog2(SYM_W);
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam logic [7:0]       COMMA_BYTE = 8'hBC;
    localparam logic [SYM_W-1:0] COMMA_NEG  = 10'b0011111010;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   nsec;
        logic [FLAG_W-1:0] flags;
        logic [SID_W-1:0]  sid;
    } stamp_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             in_frame;
        logic [SYM_W-1:0] shreg;
        logic             rd;
        logic [CRC_W-1:0] crc;
        stamp_t           fields;
    } tx_state_t;
endpackage

// File: rtl/tc_crc32_byte.sv
module tc_crc32_byte import tc_pkg::*; #(
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data_i[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_o = c;
    end
endmodule

// File: rtl/tc_frame_mux.sv
module tc_frame_mux import tc_pkg::*; #(
    parameter logic [7:0] FRAME_TYPE = 8'h01
) (
    input  stamp_t           fields_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CRC_W-1:0] crc_i,
    output logic [7:0]       byte_o
);
    logic [HDR_BITS-1:0] hdr;
    logic [CRC_W-1:0]    tail;

    always_comb begin
        int k;
        hdr  = {FRAME_TYPE, fields_i.sec, fields_i.flags, fields_i.nsec,
                fields_i.sid, {RSV_W{1'b0}}};
        tail = ~crc_i;
        k    = int'(idx_i);
        if (k < CRC_FIRST)
            byte_o = hdr[HDR_BITS-1-8*k -: 8];
        else if (k < FRAME_LEN)
            byte_o = tail[CRC_W-1-8*(k-CRC_FIRST) -: 8];
        else
            byte_o = 8'h00;
    end
endmodule

// File: rtl/tc_enc8b10b.sv
module tc_enc8b10b import tc_pkg::*; (
    input  logic [7:0]       data_i,
    input  logic             k_i,
    input  logic             rd_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             rd_o
);
    logic [5:0] c6, s6;
    logic [3:0] c4, s4;
    logic       rd6, flip6, flip4, alt7;
    logic [4:0] x;
    logic [2:0] y;

    assign x = data_i[4:0];
    assign y = data_i[7:5];

    always_comb begin
        case (x)
            5'd0:  c6 = 6'b100111;  5'd1:  c6 = 6'b011101;
            5'd2:  c6 = 6'b101101;  5'd3:  c6 = 6'b110001;
            5'd4:  c6 = 6'b110101;  5'd5:  c6 = 6'b101001;
            5'd6:  c6 = 6'b011001;  5'd7:  c6 = 6'b111000;
            5'd8:  c6 = 6'b111001;  5'd9:  c6 = 6'b100101;
            5'd10: c6 = 6'b010101;  5'd11: c6 = 6'b110100;
            5'd12: c6 = 6'b001101;  5'd13: c6 = 6'b101100;
            5'd14: c6 = 6'b011100;  5'd15: c6 = 6'b010111;
            5'd16: c6 = 6'b011011;  5'd17: c6 = 6'b100011;
            5'd18: c6 = 6'b010011;  5'd19: c6 = 6'b110010;
            5'd20: c6 = 6'b001011;  5'd21: c6 = 6'b101010;
            5'd22: c6 = 6'b011010;  5'd23: c6 = 6'b111010;
            5'd24: c6 = 6'b110011;  5'd25: c6 = 6'b100110;
            5'd26: c6 = 6'b010110;  5'd27: c6 = 6'b110110;
            5'd28: c6 = 6'b001110;  5'd29: c6 = 6'b101110;
            5'd30: c6 = 6'b011110;  default: c6 = 6'b101011;
        endcase
        if (k_i) c6 = 6'b001111;
        flip6 = ($countones(c6) != 3);
        s6    = (rd_i && (flip6 || (!k_i && x == 5'd7))) ? ~c6 : c6;
        rd6   = rd_i ^ flip6;

        alt7 = !k_i && (y == 3'd7) &&
               ((!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        case (y)
            3'd0: c4 = 4'b1011;  3'd1: c4 = 4'b1001;
            3'd2: c4 = 4'b0101;  3'd3: c4 = 4'b1100;
            3'd4: c4 = 4'b1101;  3'd5: c4 = 4'b1010;
            3'd6: c4 = 4'b0110;  default: c4 = alt7 ? 4'b0111 : 4'b1110;
        endcase
        flip4 = ($countones(c4) != 2);
        if (k_i)
            s4 = rd_i ? ~c4 : c4;
        else
            s4 = (rd6 && (flip4 || y == 3'd3)) ? ~c4 : c4;
        rd_o  = rd6 ^ flip4;
        sym_o = {s6, s4};
    end
endmodule

// File: rtl/tcode_serializer.sv
module tcode_serializer import tc_pkg::*; #(
    parameter logic [7:0]       FRAME_TYPE = 8'h01,
    parameter logic [CRC_W-1:0] CRC_POLY   = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [NS_W-1:0]   nsec_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [SID_W-1:0]  sid_i,
    output logic              line_o,
    output logic              busy_o
);
    localparam tx_state_t RESET_STATE = '{
        cnt: '0, idx: '0, in_frame: 1'b0, shreg: COMMA_NEG,
        rd: 1'b1, crc: '1, fields: '0};

    tx_state_t        q, d;
    logic             boundary, frame_more, start;
    logic [IDX_W-1:0] next_idx;
    logic [7:0]       mux_byte, enc_byte;
    logic             enc_k, enc_rd;
    logic [SYM_W-1:0] enc_sym;
    logic [CRC_W-1:0] crc_in, crc_out;

    always_comb begin
        boundary   = (q.cnt == CNT_W'(SYM_W-1));
        frame_more = q.in_frame && (q.idx != IDX_W'(FRAME_LEN-1));
        start      = boundary && !frame_more && send_i;
        next_idx   = start ? '0 : q.idx + 1'b1;
        crc_in     = start ? '1 : q.crc;
        if (start) begin
            enc_byte = FRAME_TYPE;
            enc_k    = 1'b0;
        end else if (frame_more) begin
            enc_byte = mux_byte;
            enc_k    = 1'b0;
        end else begin
            enc_byte = COMMA_BYTE;
            enc_k    = 1'b1;
        end
    end

    tc_frame_mux #(.FRAME_TYPE(FRAME_TYPE)) u_mux (
        .fields_i(q.fields), .idx_i(next_idx), .crc_i(q.crc), .byte_o(mux_byte));

    tc_crc32_byte #(.POLY(CRC_POLY)) u_crc (
        .crc_i(crc_in), .data_i(enc_byte), .crc_o(crc_out));

    tc_enc8b10b u_enc (
        .data_i(enc_byte), .k_i(enc_k), .rd_i(q.rd), .sym_o(enc_sym), .rd_o(enc_rd));

    always_comb begin
        d = q;
        if (!boundary) begin
            d.cnt   = q.cnt + 1'b1;
            d.shreg = {q.shreg[SYM_W-2:0], 1'b0};
        end else begin
            d.cnt   = '0;
            d.shreg = enc_sym;
            d.rd    = enc_rd;
            if (start) begin
                d.fields   = '{sec: sec_i, nsec: nsec_i, flags: flags_i, sid: sid_i};
                d.in_frame = 1'b1;
                d.idx      = '0;
                d.crc      = crc_out;
            end else if (frame_more) begin
                d.idx = next_idx;
                if (next_idx < IDX_W'(CRC_FIRST)) d.crc = crc_out;
            end else begin
                d.in_frame = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_STATE;
        else        q <= d;
    end

    assign line_o = q.shreg[SYM_W-1];
    assign busy_o = q.in_frame;

    // R2
    sym_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> ($countones(enc_sym) >= 4 && $countones(enc_sym) <= 6));

    // R9
    disparity_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> (q.rd ? ($countones(enc_sym) <= 5) : ($countones(enc_sym) >= 5)));

    // R4
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (q.cnt == '0 && q.idx == '0));

    // R4
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(q.idx) == IDX_W'(FRAME_LEN-1) && q.cnt == '0));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.in_frame && $past(q.cnt) != CNT_W'(SYM_W-1)) |-> $stable(q.idx));

    // R11
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.in_frame && $past(q.in_frame) && q.idx != '0) |-> $stable(q.fields));
endmodule

// File: tb/tcode_serializer_tb.sv
`timescale 1ns/1ps
module tcode_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        send_i = 1'b0;
    logic [39:0] sec_i = '0;
    logic [27:0] nsec_i = '0;
    logic [3:0]  flags_i = '0;
    logic [31:0] sid_i = '0;
    logic        line_o, busy_o;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tcode_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .send_i(send_i), .sec_i(sec_i), .nsec_i(nsec_i),
        .flags_i(flags_i), .sid_i(sid_i), .line_o(line_o), .busy_o(busy_o));

    // reference model state
    bit [9:0]   msym;
    int         mpos;
    bit         mrd;
    bit         mdata;
    int         mbidx;
    logic [7:0] mq[$];
    string      stag = "";
    int         blen = 0, last_len = 0;

    function automatic bit [5:0] t6(input bit [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101;  10: return 6'b010101; 11: return 6'b110100;
            12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
            15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
            18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
            21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
            24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
            27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
            30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    // returns {new_rd, symbol a..j}
    function automatic bit [10:0] encode(input bit [7:0] b, input bit k, input bit rd);
        bit [5:0] c6; bit [3:0] c4; bit r;
        int x, y;
        if (k) return rd ? {1'b0, 10'b1100000101} : {1'b1, 10'b0011111010};
        x = b[4:0]; y = b[7:5]; r = rd;
        c6 = t6(b[4:0]);
        if (r && ($countones(c6) != 3 || x == 7)) c6 = ~c6;
        if ($countones(c6) != 3) r = ~r;
        case (y)
            0: c4 = 4'b1011; 1: c4 = 4'b1001; 2: c4 = 4'b0101; 3: c4 = 4'b1100;
            4: c4 = 4'b1101; 5: c4 = 4'b1010; 6: c4 = 4'b0110;
            default: begin
                if ((!r && (x == 17 || x == 18 || x == 20)) || (r && (x == 11 || x == 13 || x == 14)))
                    c4 = 4'b0111;
                else
                    c4 = 4'b1110;
            end
        endcase
        if (r && ($countones(c4) != 2 || y == 3)) c4 = ~c4;
        if ($countones(c4) != 2) r = ~r;
        return {r, c6, c4};
    endfunction

    function automatic bit [31:0] crc_ref(input logic [7:0] f[20]);
        bit [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 8; j++) begin
                bit fb = c[0] ^ f[i][j];
                c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
            end
        return ~c;
    endfunction

    task automatic push_frame();
        logic [7:0] f[20];
        bit [31:0]  c;
        f[0] = 8'h01;
        for (int i = 0; i < 5; i++) f[1+i] = sec_i[39-8*i -: 8];
        f[6] = {flags_i, nsec_i[27:24]};
        f[7] = nsec_i[23:16]; f[8] = nsec_i[15:8]; f[9] = nsec_i[7:0];
        for (int i = 0; i < 4; i++) f[10+i] = sid_i[31-8*i -: 8];
        f[14] = 8'h00; f[15] = 8'h00;
        c = crc_ref(f);
        for (int i = 0; i < 4; i++) f[16+i] = c[31-8*i -: 8];
        for (int i = 0; i < 20; i++) mq.push_back(f[i]);
    endtask

    task automatic model_step();
        bit [10:0] e;
        if (!rst_n) begin
            msym = 10'b0011111010; mpos = 0; mrd = 1; mdata = 0; mbidx = 0;
            mq.delete();
            return;
        end
        if (mpos < 9) begin
            mpos++;
            return;
        end
        mpos = 0;
        if (mq.size() == 0 && send_i) push_frame();
        if (mq.size() != 0) begin
            e = encode(mq.pop_front(), 1'b0, mrd);
            mdata = 1; mbidx = 19 - mq.size();
        end else begin
            e = encode(8'hBC, 1'b1, mrd);
            mdata = 0;
        end
        mrd = e[10]; msym = e[9:0];
    endtask

    function automatic string line_tag();
        if (!mdata) return "R1";
        if (mbidx <= 5) return "R5 R9";
        if (mbidx <= 9) return "R6 R9";
        if (mbidx <= 15) return "R7 R9";
        return "R8 R9";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit el = msym[9-mpos];
        check(line_o === el, {line_tag(), " ", stag, " line"}, line_o, el);
        check(busy_o === mdata, {"R4 ", stag, " busy"}, busy_o, mdata);
        if (busy_o) blen++;
        else if (blen > 0) begin last_len = blen; blen = 0; end
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_pos(input int p);
        while (mpos != p) cyc();
    endtask

    task automatic wait_idle();
        while (mdata || mq.size() != 0) cyc();
        repeat (15) cyc();
    endtask

    task automatic send_frame(input bit [39:0] s, input bit [27:0] n,
                              input bit [3:0] fl, input bit [31:0] id);
        sec_i = s; nsec_i = n; flags_i = fl; sid_i = id;
        wait_pos(9);
        send_i = 1; cyc(); send_i = 0;
    endtask

    initial begin
        logic [19:0] cap;
        cap = '0;
        rst_n = 0;
        repeat (3) cyc();
        // R1: reset state
        check(busy_o === 1'b0 && line_o === 1'b0, "R1 reset", {busy_o, line_o}, 0);
        for (int i = 0; i < 20; i++) begin
            cap = {cap[18:0], line_o};
            rst_n = 1;
            cyc();
        end
        // R2: bit order a..j and alternating idle disparity
        check(cap == 20'b00111110101100000101, "R2 first symbols", cap, 20'b00111110101100000101);
        repeat (40) cyc();

        // R3: request in the middle of a symbol is ignored
        stag = "R3";
        wait_pos(4);
        send_i = 1; cyc(); send_i = 0;
        repeat (30) cyc();
        check(last_len == 0 && busy_o == 0, "R3 mid-symbol ignored", last_len, 0);

        // frame A with inputs changed mid-frame and a request during the frame
        stag = "R5";
        send_frame(40'h12_3456_789A, 28'hABC_DEF1, 4'b1010, 32'hDEAD_BEEF);
        stag = "R11";
        repeat (60) cyc();
        sec_i = 40'hFF_0000_FFFF; nsec_i = 28'h0123456; flags_i = 4'b0101; sid_i = 32'h1234_5678;
        stag = "R3";
        wait_pos(9);
        send_i = 1; cyc(); send_i = 0;
        stag = "R11";
        wait_idle();
        check(last_len == 200, "R4 frame length", last_len, 200);

        // frame B: all ones
        stag = "R6";
        send_frame('1, '1, 4'hF, '1);
        wait_idle();
        check(last_len == 200, "R4 frame length B", last_len, 200);

        // frame C: zeros with one flag
        stag = "R7";
        send_frame('0, '0, 4'b0001, '0);
        wait_idle();

        // frame D: mixed values hitting A7 and .3 codes
        stag = "R9";
        send_frame(40'hF1_6B_2D_EE_74, 28'h7F0_3E63, 4'b1100, 32'h9714_0B57);
        wait_idle();

        // R10: back-to-back frames from a held request
        stag = "R10";
        sec_i = 40'h00_0000_0005; nsec_i = 28'h0000100; flags_i = 4'b1001; sid_i = 32'h0000_0042;
        send_i = 1;
        while (!mdata) cyc();
        repeat (250) cyc();
        send_i = 0;
        wait_idle();
        check(last_len == 400, "R10 back-to-back length", last_len, 400);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule